// File: doc/BRIEF.md
# Two-Context Shared Front-End Arbiter

This block shares one front-end resource, such as a decoded-instruction store or a decoder port, between two hardware thread contexts. Each cycle it grants the resource to at most one context, reports which context holds it, and keeps a next-fetch pointer for each context. Each pointer moves forward by a fixed step on every cycle in which its context holds the grant.

The block also tracks which contexts are running. There are three operating modes: only context 0 runs, only context 1 runs, or both run. A halt command stops a context. A wake interrupt brings a halted context back. While both contexts run and both request, the grant alternates on every clock. While only one context runs, that context can use every cycle. The block leaves reset with context 0 running and context 1 halted.

The design has two small state machines. The mode machine has states MODE_SOLO0, MODE_SOLO1 and MODE_DUAL. Its transitions are:
- SOLO0 to DUAL on a wake to context 1.
- SOLO1 to DUAL on a wake to context 0.
- DUAL to SOLO1 on a halt of context 0 alone.
- DUAL to SOLO0 on a halt of context 1, or on a halt of both contexts in the same cycle.

The turn machine has states TURN_T0 and TURN_T1. It moves to the other context's turn whenever a grant is given, and holds its state on cycles with no grant.

Top module: `thread_fe_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the mode is 2'b01, the grant is 2'b00, the pointer of context 0 equals RST_PTR0 and the pointer of context 1 equals RST_PTR1. The turn starts at context 0, so the first cycle in which both contexts run and request grants context 0.
- R2: In the mode output, bit t is set exactly when context t is active: 2'b01 means only context 0 runs, 2'b10 means only context 1 runs, and 2'b11 means both run. The value 2'b00 never appears.
- R3: In dual mode, a halt on context 0 alone gives mode 2'b10 on the next cycle. A halt on context 1 alone, or a halt on both contexts in the same cycle, gives mode 2'b01 on the next cycle.
- R4: In a single-task mode, a wake to the halted context gives mode 2'b11 on the next cycle, even if a halt for that same context arrives in the same cycle. A wake to a context that is already active has no effect.
- R5: A halt aimed at the only active context is ignored, and the mode stays unchanged.
- R6: A context receives the grant only if it is active and requesting in that cycle. A request from a halted context is ignored. At most one grant bit is set. The grant ID equals grant bit 1, so it reads 0 when there is no grant.
- R7: When only one context is active and it requests, it receives the grant in that same cycle, on every such cycle.
- R8: When both contexts are active and requesting in consecutive cycles, the granted context changes on every cycle.
- R9: In dual mode, if the context whose turn it is does not request, the other context is granted if it requests. The turn always passes to the context that was not granted most recently.
- R10: A context's pointer increases by STEP, modulo 2^PTR_W, on the cycle after each cycle in which that context holds the grant. Otherwise the pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 2 | Per-context request for the shared resource |
| halt_cmd | input | 2 | Per-context halt command, sampled on the clock |
| wake_irq | input | 2 | Per-context wake interrupt, sampled on the clock |
| grant | output | 2 | Per-context grant, at most one bit set |
| grant_id | output | 1 | Index of the granted context (0 when there is no grant) |
| run_mode | output | 2 | Operating mode, one bit per active context |
| next_ptr | output | 2 x PTR_W | Packed per-context next-fetch pointers, context 0 in the low slice |

## Verification
The assertions assume the request, halt and wake inputs are stable across each rising edge. They also assume the pointer step is a compile-time constant, so that one cycle of history is enough to check each pointer advance. The bench changes all inputs only on falling edges and holds them steady for a full cycle. Its stimulus includes simultaneous halts, a halt and a wake on the same context in the same cycle, and wakes to contexts that are already running, so that every transition the mode machine defines is reached with inputs that are legal.

// File: rtl/thread_fe_arb_pkg.sv
package thread_fe_arb_pkg;

    localparam int NCTX = 2;

    // Mode encoding: bit t set means context t is active.
    typedef enum logic [1:0] {
        MODE_SOLO0 = 2'b01,
        MODE_SOLO1 = 2'b10,
        MODE_DUAL  = 2'b11
    } run_mode_e;

    typedef enum logic {
        TURN_T0 = 1'b0,
        TURN_T1 = 1'b1
    } turn_e;

endpackage

// File: rtl/ctx_mode_fsm.sv
module ctx_mode_fsm
    import thread_fe_arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCTX-1:0] halt_cmd,
    input  logic [NCTX-1:0] wake_irq,
    output run_mode_e       mode_q
);

    run_mode_e mode_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SOLO0;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Transitions.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_SOLO0: begin
                // A halt to context 0 is dropped: it is the only active context.
                if (wake_irq[1]) begin
                    mode_d = MODE_DUAL;
                end
            end
            MODE_SOLO1: begin
                if (wake_irq[0]) begin
                    mode_d = MODE_DUAL;
                end
            end
            MODE_DUAL: begin
                // If both halts arrive together, context 0 keeps running.
                if (halt_cmd[1]) begin
                    mode_d = MODE_SOLO0;
                end else if (halt_cmd[0]) begin
                    mode_d = MODE_SOLO1;
                end
            end
            default: mode_d = MODE_SOLO0;
        endcase
    end

endmodule

// File: rtl/turn_arbiter.sv
module turn_arbiter
    import thread_fe_arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCTX-1:0] req,
    input  logic [NCTX-1:0] active,
    output logic [NCTX-1:0] gnt,
    output logic            gnt_id
);

    turn_e           turn_q;
    turn_e           turn_d;
    logic [NCTX-1:0] elig;

    assign elig = req & active;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            turn_q <= TURN_T0;
        end else begin
            turn_q <= turn_d;
        end
    end

    // Grant outputs: the turn holder goes first, otherwise fill with the other context.
    always_comb begin
        gnt = '0;
        unique case (turn_q)
            TURN_T0: begin
                if (elig[0])      gnt = 2'b01;
                else if (elig[1]) gnt = 2'b10;
            end
            TURN_T1: begin
                if (elig[1])      gnt = 2'b10;
                else if (elig[0]) gnt = 2'b01;
            end
            default: gnt = '0;
        endcase
        gnt_id = gnt[1];
    end

    // The turn passes away from whichever context was just granted.
    always_comb begin
        turn_d = turn_q;
        if (gnt[0]) begin
            turn_d = TURN_T1;
        end else if (gnt[1]) begin
            turn_d = TURN_T0;
        end
    end

endmodule

// File: rtl/fetch_ptr_bank.sv
module fetch_ptr_bank
    import thread_fe_arb_pkg::*;
#(
    parameter int          PTR_W    = 32,
    parameter int          STEP     = 16,
    parameter logic [63:0] RST_PTR0 = 64'h0,
    parameter logic [63:0] RST_PTR1 = 64'h1000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCTX-1:0]            adv,
    output logic [NCTX-1:0][PTR_W-1:0] ptr_q
);

    localparam logic [PTR_W-1:0] INC    = PTR_W'(STEP);
    localparam logic [PTR_W-1:0] INIT_0 = PTR_W'(RST_PTR0);
    localparam logic [PTR_W-1:0] INIT_1 = PTR_W'(RST_PTR1);

    for (genvar t = 0; t < NCTX; t++) begin : g_ctx
        localparam logic [PTR_W-1:0] INIT_T = (t == 0) ? INIT_0 : INIT_1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q[t] <= INIT_T;
            end else if (adv[t]) begin
                ptr_q[t] <= ptr_q[t] + INC;
            end
        end
    end

endmodule

// File: rtl/thread_fe_arb.sv
module thread_fe_arb
    import thread_fe_arb_pkg::*;
#(
    parameter int          PTR_W    = 32,
    parameter int          STEP     = 16,
    parameter logic [63:0] RST_PTR0 = 64'h0,
    parameter logic [63:0] RST_PTR1 = 64'h1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           fetch_req,
    input  logic [1:0]           halt_cmd,
    input  logic [1:0]           wake_irq,
    output logic [1:0]           grant,
    output logic                 grant_id,
    output logic [1:0]           run_mode,
    output logic [1:0][PTR_W-1:0] next_ptr
);

    run_mode_e       mode_q;
    logic [NCTX-1:0] active;
    logic [NCTX-1:0] gnt;
    logic            gnt_id;

    ctx_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_cmd (halt_cmd),
        .wake_irq (wake_irq),
        .mode_q   (mode_q)
    );

    assign active = mode_q;

    turn_arbiter u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (fetch_req),
        .active (active),
        .gnt    (gnt),
        .gnt_id (gnt_id)
    );

    fetch_ptr_bank #(
        .PTR_W    (PTR_W),
        .STEP     (STEP),
        .RST_PTR0 (RST_PTR0),
        .RST_PTR1 (RST_PTR1)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (gnt),
        .ptr_q (next_ptr)
    );

    assign grant    = gnt;
    assign grant_id = gnt_id;
    assign run_mode = active;

endmodule

// File: rtl/thread_fe_arb_chk.sv
module thread_fe_arb_chk #(
    parameter int PTR_W = 32,
    parameter int STEP  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            fetch_req,
    input logic [1:0]            halt_cmd,
    input logic [1:0]            wake_irq,
    input logic [1:0]            grant,
    input logic                  grant_id,
    input logic [1:0]            run_mode,
    input logic [1:0][PTR_W-1:0] next_ptr
);

    localparam logic [PTR_W-1:0] INC = PTR_W'(STEP);

    logic [1:0] elig;
    assign elig = fetch_req & run_mode;

    p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_mode != 2'b00);

    p_dual_halt0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == 2'b11 && halt_cmd == 2'b01) |=> run_mode == 2'b10);

    p_dual_halt1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == 2'b11 && halt_cmd[1]) |=> run_mode == 2'b01);

    p_wake_solo0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == 2'b01 && wake_irq[1]) |=> run_mode == 2'b11);

    p_lone_halt_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == 2'b01 && !wake_irq[1]) |=> run_mode == 2'b01);

    p_grant_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~elig) == 2'b00) && (grant_id == grant[1]));

    p_solo_every_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode != 2'b11 && elig != 2'b00) |-> grant == elig);

    p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == 2'b11) |=> (elig != 2'b11 || grant != $past(grant)));

    p_no_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != 2'b00) |-> grant != 2'b00);

    p_ptr0_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |=> next_ptr[0] == PTR_W'($past(next_ptr[0]) + INC));

    p_ptr1_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !grant[1] |=> $stable(next_ptr[1]));

endmodule

bind thread_fe_arb thread_fe_arb_chk #(.PTR_W(PTR_W), .STEP(STEP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .halt_cmd  (halt_cmd),
    .wake_irq  (wake_irq),
    .grant     (grant),
    .grant_id  (grant_id),
    .run_mode  (run_mode),
    .next_ptr  (next_ptr)
);

// File: tb/thread_fe_arb_tb.sv
module thread_fe_arb_tb;

    localparam int         PTR_W = 8;
    localparam int         STEP  = 4;
    localparam logic [7:0] P0    = 8'hF0;
    localparam logic [7:0] P1    = 8'h40;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [1:0]            fetch_req = '0;
    logic [1:0]            halt_cmd = '0;
    logic [1:0]            wake_irq = '0;
    logic [1:0]            grant;
    logic                  grant_id;
    logic [1:0]            run_mode;
    logic [1:0][PTR_W-1:0] next_ptr;

    always #10 clk = ~clk;

    thread_fe_arb #(.PTR_W(PTR_W), .STEP(STEP), .RST_PTR0(64'(P0)), .RST_PTR1(64'(P1))) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .halt_cmd(halt_cmd),
        .wake_irq(wake_irq), .grant(grant), .grant_id(grant_id),
        .run_mode(run_mode), .next_ptr(next_ptr)
    );

    typedef struct {
        logic [1:0] gnt;
        logic       id;
        logic [1:0] mode;
        logic [7:0] p0;
        logic [7:0] p1;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Bench model state, updated from the requirements.
    logic [1:0] m_mode = 2'b01;
    logic       m_turn = 1'b0;
    logic [7:0] m_p0 = P0;
    logic [7:0] m_p1 = P1;

    task automatic check_val(input string tag, input string field, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, field, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of inputs at the falling edge, push the expected outputs.
    task automatic step(input logic [1:0] req, input logic [1:0] hlt, input logic [1:0] wk, input string tag);
        exp_t       e;
        logic [1:0] el;
        logic [1:0] g;
        @(negedge clk);
        fetch_req = req;
        halt_cmd  = hlt;
        wake_irq  = wk;
        el = req & m_mode;
        if (el == 2'b11) g = m_turn ? 2'b10 : 2'b01;
        else             g = el;
        e.gnt = g; e.id = g[1]; e.mode = m_mode; e.p0 = m_p0; e.p1 = m_p1; e.tag = tag;
        q.push_back(e);
        if (g[0]) begin m_turn = 1'b1; m_p0 = m_p0 + 8'(STEP); end
        if (g[1]) begin m_turn = 1'b0; m_p1 = m_p1 + 8'(STEP); end
        case (m_mode)
            2'b01:   if (wk[1]) m_mode = 2'b11;
            2'b10:   if (wk[0]) m_mode = 2'b11;
            default: if (hlt[1]) m_mode = 2'b01; else if (hlt[0]) m_mode = 2'b10;
        endcase
    endtask

    // Monitor: compare a quarter period after the falling edge.
    always @(negedge clk) begin
        #5;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check_val({e.tag, " R6"}, "grant", int'(grant), int'(e.gnt));
            check_val({e.tag, " R6"}, "grant_id", int'(grant_id), int'(e.id));
            check_val({e.tag, " R2"}, "mode", int'(run_mode), int'(e.mode));
            check_val({e.tag, " R10"}, "ptr0", int'(next_ptr[0]), int'(e.p0));
            check_val({e.tag, " R10"}, "ptr1", int'(next_ptr[1]), int'(e.p1));
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        // R1: reset values.
        check_val("R1", "mode", int'(run_mode), 2'b01);
        check_val("R1", "grant", int'(grant), 0);
        check_val("R1", "ptr0", int'(next_ptr[0]), int'(P0));
        check_val("R1", "ptr1", int'(next_ptr[1]), int'(P1));
        @(negedge clk);
        rst_n = 1'b1;
        // Still at reset values on the first cycle after release.
        step(2'b00, 2'b00, 2'b10, "R1");      // R4: wake context 1 from solo0
        step(2'b11, 2'b00, 2'b00, "R1");      // first grant in dual goes to context 0
        for (int i = 0; i < 5; i++) step(2'b11, 2'b00, 2'b00, "R8");
        step(2'b10, 2'b00, 2'b00, "R9");
        step(2'b10, 2'b00, 2'b00, "R9");
        step(2'b01, 2'b00, 2'b00, "R9");
        step(2'b11, 2'b00, 2'b00, "R9");
        step(2'b00, 2'b00, 2'b00, "R6");
        step(2'b11, 2'b01, 2'b00, "R3");      // halt context 0 alone
        for (int i = 0; i < 4; i++) step(2'b11, 2'b00, 2'b00, "R7");
        step(2'b10, 2'b10, 2'b00, "R5");      // halt to the only active context
        step(2'b11, 2'b00, 2'b10, "R4");      // wake to an active context
        step(2'b00, 2'b00, 2'b01, "R4");      // wake context 0 -> dual
        step(2'b11, 2'b11, 2'b00, "R3");      // both halts -> solo0
        for (int i = 0; i < 6; i++) step(2'b11, 2'b00, 2'b00, "R7");
        for (int i = 0; i < 3; i++) step(2'b01, 2'b00, 2'b00, "R10");
        step(2'b00, 2'b01, 2'b00, "R5");
        step(2'b00, 2'b10, 2'b10, "R4");      // halt and wake on context 1 -> dual
        step(2'b11, 2'b00, 2'b00, "R8");
        step(2'b11, 2'b00, 2'b00, "R8");
        step(2'b00, 2'b00, 2'b00, "R10");
        repeat (2) @(negedge clk);
        #8;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule